// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address. It reads up to three 64-bit table entries from memory, one at a time, starting from a root table whose physical page number comes from a configuration input. The walk can stop on a leaf entry at any of the three levels. A leaf on the first entry read maps a 1 GB page, a leaf on the second maps a 2 MB page, and a leaf on the third maps a 4 KB page. The block returns the physical address and the page size, or it reports a page fault.

A client presents a request that carries the virtual address and the access kind, and waits for a one-cycle response. The response is tagged with the address space identifier that was on the configuration input when the request was accepted, so that a translation cache can file the result. The block handles one walk at a time. Entry reads go out on a valid/ready request channel, and data comes back on a valid-only response channel.

Top module: `ptw_walker`

## Requirements
- R1: If bits 63:39 of the virtual address are not all equal to bit 38, the request ends with a fault and the block reads no entry from memory.
- R2: The first entry read is at root_ppn*4096 + VA[38:30]*8. Each later read is at next_ppn*4096 + vpn*8, where next_ppn is entry bits 53:10 and vpn is VA[29:21] on the second read and VA[20:12] on the third.
- R3: Entry flag bits are V=bit0, R=bit1, W=bit2, X=bit3, A=bit6 and D=bit7. An entry with V=0, or with W=1 and R=0, ends the walk with a fault.
- R4: An entry with R, W and X all clear points to the next table. If such an entry is the third one read, the walk ends with a fault, so a walk never makes more than three reads.
- R5: A walk that succeeds reports rsp_size 2 for a leaf on the first read (1 GB), 1 for a leaf on the second read (2 MB) and 0 for a leaf on the third read (4 KB).
- R6: A leaf on the first read must have entry bits 27:10 equal to zero. A leaf on the second read must have entry bits 18:10 equal to zero. Otherwise the walk faults.
- R7: req_acc selects the access kind: 0 is read, 1 is write, 2 is execute. The walk faults when A=0. It also faults on a read with R=0, on a write with W=0 or D=0, and on an execute with X=0.
- R8: On success, rsp_paddr is the leaf's page number times 4096 plus VA[11:0]. For a 2 MB page, bits 20:12 come from VA[20:12]. For a 1 GB page, bits 29:12 come from VA[29:12].
- R9: rsp_asid equals the value cfg_asid had in the cycle the request was accepted, even if cfg_asid changes later.
- R10: req_ready is high only when the block is idle. rsp_valid is a single-cycle pulse. req_ready stays low from acceptance through the response cycle.
- R11: While mem_req_valid is high and mem_req_ready is low, the request stays asserted and mem_req_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_root_ppn | input | 44 | Physical page number of the root table |
| cfg_asid | input | 16 | Address space identifier attached to responses |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the entry read |
| mem_req_addr | output | 56 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_paddr | output | 56 | Translated physical address |
| rsp_size | output | 2 | Page size code: 0 is 4 KB, 1 is 2 MB, 2 is 1 GB |
| rsp_asid | output | 16 | Identifier captured at request acceptance |

## Verification
The bench builds the walker with its default parameters: three levels, 9-bit index fields and a 44-bit page number. With these values every leaf depth, both superpage misalignment fields and a pointer on the final read can all be reached in the random walks. Root and pointer page numbers are drawn across all 44 bits, and random stalls on the memory request side exercise the hold behaviour. The same random walks also check each entry address against the expected value for its level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {EV_FAULT, EV_DESCEND, EV_LEAF} pte_ev_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_RESP} walk_st_e;

  localparam int FLG_V   = 0;
  localparam int FLG_R   = 1;
  localparam int FLG_W   = 2;
  localparam int FLG_X   = 3;
  localparam int FLG_A   = 6;
  localparam int FLG_D   = 7;
  localparam int PPN_LSB = 10;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int LEVELS = 3,
  parameter int VPN_W  = 9,
  parameter int PPN_W  = 44,
  parameter int LVL_W  = 2
) (
  input  logic [PPN_W-1:0]        ppn,
  input  logic [LEVELS*VPN_W-1:0] vpns,
  input  logic [LVL_W-1:0]        level,
  output logic [PPN_W+VPN_W+2:0]  addr
);
  logic [VPN_W-1:0] vpn_arr [LEVELS];
  logic [VPN_W-1:0] vpn_sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_split
    assign vpn_arr[g] = vpns[g*VPN_W +: VPN_W];
  end

  always_comb begin
    vpn_sel = '0;
    for (int i = 0; i < LEVELS; i++)
      if (level == LVL_W'(i)) vpn_sel = vpn_arr[i];
  end

  // Entries are 8 bytes, so the index lands on bits [VPN_W+2:3].
  assign addr = {ppn, vpn_sel, 3'b000};
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval import ptw_pkg::*; #(
  parameter int LEVELS = 3,
  parameter int VPN_W  = 9,
  parameter int LVL_W  = 2,
  parameter int PTE_W  = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       acc,
  output pte_ev_e          ev
);
  logic v, r, w, x, a, d, misal, perm_ok;
  logic unused_pte_bits;

  assign unused_pte_bits = ^{pte[PTE_W-1:PPN_LSB+VPN_W*(LEVELS-1)], pte[9:8], pte[5:4]};
  assign v = pte[FLG_V];
  assign r = pte[FLG_R];
  assign w = pte[FLG_W];
  assign x = pte[FLG_X];
  assign a = pte[FLG_A];
  assign d = pte[FLG_D];

  always_comb begin
    misal = 1'b0;
    for (int i = 0; i < LEVELS-1; i++)
      if (i < int'(level) && pte[PPN_LSB+i*VPN_W +: VPN_W] != '0) misal = 1'b1;

    case (acc_e'(acc))
      ACC_LOAD:  perm_ok = a & r;
      ACC_STORE: perm_ok = a & w & d;
      ACC_FETCH: perm_ok = a & x;
      default:   perm_ok = 1'b0;
    endcase

    if (!v || (w && !r))  ev = EV_FAULT;
    else if (r || x)      ev = (misal || !perm_ok) ? EV_FAULT : EV_LEAF;
    else if (level == '0) ev = EV_FAULT;
    else                  ev = EV_DESCEND;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
  parameter int XLEN   = 64,
  parameter int VA_W   = 39,
  parameter int LEVELS = 3,
  parameter int VPN_W  = 9,
  parameter int PPN_W  = 44,
  parameter int ASID_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PPN_W-1:0]            cfg_root_ppn,
  input  logic [ASID_W-1:0]           cfg_asid,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [XLEN-1:0]             req_vaddr,
  input  logic [1:0]                  req_acc,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [PPN_W+VPN_W+2:0]      mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [XLEN-1:0]             mem_rsp_data,
  output logic                        rsp_valid,
  output logic                        rsp_fault,
  output logic [PPN_W+VPN_W+2:0]      rsp_paddr,
  output logic [$clog2(LEVELS)-1:0]   rsp_size,
  output logic [ASID_W-1:0]           rsp_asid
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int OFF_W = VPN_W + $clog2(XLEN/8);
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int TOP_W = PPN_W - (LEVELS-1)*VPN_W;
  localparam int VPN_T = LEVELS*VPN_W;

  walk_st_e          state_q;
  logic [LVL_W-1:0]  level_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic              canon;
  logic [PPN_W-1:0]  ptr_ppn, ag_ppn;
  logic [LVL_W-1:0]  ag_lvl;
  logic [VPN_T-1:0]  ag_vpns;
  logic [PA_W-1:0]   ag_addr, leaf_pa;
  pte_ev_e           ev;

  assign canon   = (&req_vaddr[XLEN-1:VA_W-1]) | ~(|req_vaddr[XLEN-1:VA_W-1]);
  assign ptr_ppn = mem_rsp_data[PPN_LSB +: PPN_W];
  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    if (state_q == ST_IDLE) begin
      ag_ppn  = cfg_root_ppn;
      ag_lvl  = LVL_W'(LEVELS-1);
      ag_vpns = req_vaddr[VA_W-1:OFF_W];
    end else begin
      ag_ppn  = ptr_ppn;
      ag_lvl  = level_q - 1'b1;
      ag_vpns = va_q[VA_W-1:OFF_W];
    end
  end

  ptw_addr_gen #(.LEVELS(LEVELS), .VPN_W(VPN_W), .PPN_W(PPN_W), .LVL_W(LVL_W)) u_addr (
    .ppn(ag_ppn), .vpns(ag_vpns), .level(ag_lvl), .addr(ag_addr)
  );

  ptw_pte_eval #(.LEVELS(LEVELS), .VPN_W(VPN_W), .LVL_W(LVL_W), .PTE_W(XLEN)) u_eval (
    .pte(mem_rsp_data), .level(level_q), .acc(acc_q), .ev(ev)
  );

  // Superpages take their low page-number fields from the virtual address.
  always_comb begin
    leaf_pa[OFF_W-1:0] = va_q[OFF_W-1:0];
    for (int i = 0; i < LEVELS-1; i++)
      leaf_pa[OFF_W+i*VPN_W +: VPN_W] = (i < int'(level_q)) ?
        va_q[OFF_W+i*VPN_W +: VPN_W] : mem_rsp_data[PPN_LSB+i*VPN_W +: VPN_W];
    leaf_pa[PA_W-1 -: TOP_W] = mem_rsp_data[PPN_LSB+(LEVELS-1)*VPN_W +: TOP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      level_q       <= '0;
      va_q          <= '0;
      acc_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_size      <= '0;
      rsp_asid      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q     <= req_vaddr[VA_W-1:0];
          acc_q    <= req_acc;
          rsp_asid <= cfg_asid;
          if (!canon) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            rsp_size  <= '0;
            state_q   <= ST_RESP;
          end else begin
            level_q       <= ag_lvl;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= ag_addr;
            state_q       <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state_q       <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          case (ev)
            EV_DESCEND: begin
              level_q       <= ag_lvl;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ag_addr;
              state_q       <= ST_REQ;
            end
            EV_LEAF: begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= leaf_pa;
              rsp_size  <= level_q;
              state_q   <= ST_RESP;
            end
            default: begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              rsp_size  <= '0;
              state_q   <= ST_RESP;
            end
          endcase
        end
        default: begin
          rsp_valid <= 1'b0;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int LEVELS = 3,
  parameter int PA_W   = 56
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic [PA_W-1:0]           mem_req_addr,
  input logic                      rsp_valid,
  input logic                      rsp_fault,
  input logic [$clog2(LEVELS)-1:0] rsp_size
);
  logic [3:0] nreads;

  always_ff @(posedge clk) begin
    if (rst) nreads <= '0;
    else if (req_valid && req_ready) nreads <= '0;
    else if (mem_req_valid && mem_req_ready) nreads <= nreads + 4'd1;
  end

  AST_NOREAD_MEANS_FAULT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && nreads == 4'd0) |-> rsp_fault); // R1
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2
  AST_READS_BOUND: assert property (@(posedge clk) disable iff (rst)
    nreads <= 4'(LEVELS)); // R4
  AST_SIZE_VS_READS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (nreads == 4'(LEVELS) - 4'(rsp_size))); // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_BUSY_ON_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.LEVELS(LEVELS), .PA_W(PPN_W+VPN_W+3)) u_chk (.*);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [43:0] cfg_root_ppn = '0;
  logic [15:0] cfg_asid = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_fault;
  logic [55:0] rsp_paddr;
  logic [1:0]  rsp_size;
  logic [15:0] rsp_asid;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] ptes [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u_ptw_walker (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [43:0] rnd_ppn();
    logic [63:0] r = {$urandom(), $urandom()};
    return r[43:0];
  endfunction

  // Expected result built from the requirements alone.
  task automatic ref_walk(input logic [63:0] va, input logic [1:0] acc,
                          output bit f, output logic [55:0] pa, output logic [1:0] sz, output int nr);
    f = 1'b1; pa = '0; sz = '0; nr = 0;
    if (!((&va[63:38]) || !(|va[63:38]))) return;
    for (int l = 2; l >= 0; l--) begin
      logic [63:0] p = ptes[l];
      nr++;
      if (!p[0] || (p[2] && !p[1])) return;
      if (p[1] || p[3]) begin
        logic [55:0] m;
        bit ok;
        if (l >= 1 && p[18:10] != 0) return;
        if (l == 2 && p[27:19] != 0) return;
        ok = p[6];
        if (acc == 2'd0) ok = ok && p[1];
        else if (acc == 2'd1) ok = ok && p[2] && p[7];
        else ok = ok && p[3];
        if (!ok) return;
        m  = (56'd1 << (12 + 9*l)) - 56'd1;
        pa = ({p[53:10], 12'b0} & ~m) | (va[55:0] & m);
        sz = 2'(l);
        f  = 1'b0;
        return;
      end
      if (l == 0) return;
    end
  endtask

  task automatic do_walk(input logic [63:0] va, input logic [1:0] acc, input logic [15:0] asid);
    bit ef; logic [55:0] epa; logic [1:0] esz; int erd;
    int lvl = 2, reads = 0, guard = 0, stall;
    bit got = 0;
    logic [43:0] tppn;
    logic [55:0] held;
    ref_walk(va, acc, ef, epa, esz, erd);
    tppn  = cfg_root_ppn;
    stall = $urandom % 3;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle ready", 64'(req_ready), 64'd1);
    cfg_asid = asid; req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_asid  = ~asid;
    chk(req_ready == 1'b0, "R10 busy after accept", 64'(req_ready), 64'd0);
    held = mem_req_addr;
    while (!got && guard < 100) begin
      guard++;
      if (rsp_valid) begin
        got = 1;
        chk(rsp_fault == ef, "R1 R3 R4 R6 R7 fault", 64'(rsp_fault), 64'(ef));
        chk(reads == erd, "R1 R2 R4 read count", 64'(reads), 64'(erd));
        chk(rsp_asid == asid, "R9 asid", 64'(rsp_asid), 64'(asid));
        if (!ef) begin
          chk(rsp_paddr == epa, "R8 paddr", 64'(rsp_paddr), 64'(epa));
          chk(rsp_size == esz, "R5 size", 64'(rsp_size), 64'(esz));
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R10 pulse and ready", {rsp_valid, req_ready}, 64'b01);
      end else if (mem_req_valid) begin
        if (lvl < 0) begin
          chk(0, "R4 read past last level", 64'(reads), 64'd3);
          mem_req_ready = 1'b1; @(negedge clk); mem_req_ready = 1'b0;
          mem_rsp_valid = 1'b1; mem_rsp_data = '0; @(negedge clk); mem_rsp_valid = 1'b0;
          continue;
        end
        if (stall > 0) begin
          held = mem_req_addr;
          stall--;
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == held, "R11 hold", 64'(mem_req_addr), 64'(held));
          continue;
        end
        chk(mem_req_addr == {tppn, va[12 + 9*lvl +: 9], 3'b000}, "R2 entry address",
            64'(mem_req_addr), 64'({tppn, va[12 + 9*lvl +: 9], 3'b000}));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = ptes[lvl];
        tppn = ptes[lvl][53:10];
        lvl--; reads++;
        stall = $urandom % 3;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    if (!got) chk(0, "R10 response timeout", 64'(guard), 64'd0);
  endtask

  // Pointers above the leaf level, the given leaf at leaf_l.
  task automatic build(input int leaf_l, input logic [43:0] lppn, input logic [7:0] flg);
    for (int l = 2; l >= 0; l--) begin
      if (l > leaf_l) ptes[l] = {10'b0, rnd_ppn(), 10'h001};
      else if (l == leaf_l) ptes[l] = {10'b0, lppn, 2'b00, flg};
      else ptes[l] = {$urandom(), $urandom()};
    end
  endtask

  function automatic logic [63:0] canon_va(input logic [38:0] v);
    return {{25{v[38]}}, v};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R10 reset state",
        {req_ready, mem_req_valid, rsp_valid}, 64'b100);

    cfg_root_ppn = 44'h0_1234_5678;
    // R1 non-canonical address
    build(0, rnd_ppn(), 8'hCF);
    do_walk(64'h0001_0000_0000_1000, 2'd0, 16'h00A1);
    // R3 invalid root entry
    ptes[2] = 64'h0;
    do_walk(canon_va(39'h12_3456_7000), 2'd0, 16'h00A2);
    // R3 write without read at second level
    build(1, 44'h0_0000_0400, 8'hC5);
    do_walk(canon_va(39'h40_0020_1000), 2'd1, 16'h00A3);
    // R4 pointer on third read
    build(0, rnd_ppn(), 8'h01);
    do_walk(canon_va(39'h7F_FFFF_F000), 2'd0, 16'h00A4);
    // R6 misaligned 1 GB leaf (bit 19 set) and 2 MB leaf (bit 10 set)
    build(2, 44'h0_0000_0200, 8'hCF);
    do_walk(canon_va(39'h01_2345_6789), 2'd0, 16'h00A5);
    build(1, 44'h0_0000_0001, 8'hCF);
    do_walk(canon_va(39'h01_2345_6789), 2'd0, 16'h00A6);
    // R7 write with D clear, read with A clear, execute without X
    build(0, 44'h0_ABCD_EF01, 8'h47);
    do_walk(canon_va(39'h00_1000_2000), 2'd1, 16'h00A7);
    build(0, 44'h0_ABCD_EF01, 8'h87);
    do_walk(canon_va(39'h00_1000_2000), 2'd0, 16'h00A8);
    build(0, 44'h0_ABCD_EF01, 8'hC7);
    do_walk(canon_va(39'h00_1000_2000), 2'd2, 16'h00A9);
    // R5 R8 good 4 KB, 2 MB and 1 GB pages with a high (negative) address
    build(0, 44'hF_FFFF_FFFF_F, 8'hCB);
    do_walk(canon_va(39'h55_5555_5ABC), 2'd2, 16'h00AA);
    build(1, 44'h0_0123_4600, 8'hC3);
    do_walk(canon_va(39'h7A_BCDE_F123), 2'd0, 16'h00AB);
    build(2, 44'h0_00AB_C000 & 44'hFFF_FFFC_0000, 8'hC7);
    do_walk(canon_va(39'h4F_EDCB_A987), 2'd1, 16'h00AC);

    for (int t = 0; t < 300; t++) begin
      int lf = $urandom % 3;
      logic [7:0] flg;
      logic [43:0] pp = rnd_ppn();
      logic [38:0] v = {$urandom(), $urandom()};
      logic [63:0] va = canon_va(v);
      case ($urandom % 6)
        0: flg = 8'(($urandom % 256));
        1: flg = 8'hC3;
        2: flg = 8'hC7;
        3: flg = 8'hC9;
        4: flg = 8'hCB;
        default: flg = 8'hCF;
      endcase
      if ($urandom % 4 != 0) pp[17:0] = (lf == 2) ? 18'h0 : (lf == 1) ? {pp[17:9], 9'h0} : pp[17:0];
      cfg_root_ppn = rnd_ppn();
      build(lf, pp, flg);
      if ($urandom % 12 == 0) ptes[2 - ($urandom % 3)] = {$urandom(), $urandom()};
      if ($urandom % 16 == 0) va[39 + ($urandom % 25)] ^= 1'b1;
      do_walk(va, 2'($urandom % 3), 16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule